// File: doc/BRIEF.md
# Mailbox-Gated Power Request Sequencer

This block owns one power-request control bit of a subsystem and changes it only after a mailbox exchange has shown that the subsystem is in its active state. A single start pulse, with a flag that selects raising or dropping the request, launches the whole sequence. The block masters a plain 32-bit register bus. It waits for the mailbox to go idle, loads the mailbox data word, issues the mailbox command and waits for idle again. Only then does it read, modify and write back the power control register.

Each of the two idle waits is bounded by a timeout that counts coarse time units from a clock prescaler. If a wait expires, the sequence stops without touching the power register and reports which wait failed. When the hardware-revision input shows an older part, the mailbox exchange is skipped and only the read-modify-write is done. Completion is signalled by a one-cycle done pulse. The error and timeout indications stay set until the next accepted start.

Top module: `pwrreq_seq`

## Requirements
- R1: On a start with hw_rev >= MIN_REV, the first bus access is a read of address 0x161300, and it is repeated until a read returns bit 31 equal to 0. The other bits of that read are ignored.
- R2: After that first wait, the block writes address 0x161304 with 32'h1 when enable_req was 1 at start, or with 32'h0 when enable_req was 0.
- R3: Next, the block writes address 0x161300 with 32'h8000_0001: bit 31 is set, bits 7:0 hold 0x01, and every other bit is 0.
- R4: After the command write, the block reads 0x161300 repeatedly until bit 31 reads 0. No access to PWR_ADDR happens before that read.
- R5: Each wait phase aborts once TIMEOUT_TICKS × TICK_CYCLES clock cycles have passed since the phase began. An abort sets error, sets timed_out bit 0 for the first wait or timed_out bit 1 for the second, pulses done, and issues no access to PWR_ADDR.
- R6: After a good handshake, the block reads PWR_ADDR and writes back the same word with bit PWR_BIT set (enable) or cleared (disable). All other bits are kept.
- R7: On a start with hw_rev < MIN_REV, the only accesses are one read of PWR_ADDR followed by one write of PWR_ADDR, done as in R6.
- R8: A start pulse that arrives while a sequence is in progress is ignored, and its enable_req value has no effect on that sequence.
- R9: done is high for exactly one cycle at the end of every sequence. error and timed_out hold their value until the next accepted start, and that start clears them.
- R10: At most one of bus_rd and bus_wr is high in any cycle. An access holds its strobe, address and write data until a cycle with bus_ready high, and bus_rdata is used only in that cycle.
- R11: After reset, bus_rd, bus_wr, done, error and timed_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only when idle |
| enable_req | input | 1 | 1 = raise the power request, 0 = drop it; sampled with start |
| hw_rev | input | REV_W | Hardware revision; values below MIN_REV skip the mailbox |
| bus_addr | output | 32 | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_wr | output | 1 | Write strobe, held until bus_ready |
| bus_rd | output | 1 | Read strobe, held until bus_ready |
| bus_rdata | input | 32 | Read data, valid when bus_ready is high |
| bus_ready | input | 1 | Completes the current access |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | Sequence aborted; held until the next start |
| timed_out | output | 2 | Bit 0: first wait expired; bit 1: second wait expired |

## Verification
The assertions assume that bus_ready goes high only while a strobe is raised. They also assume that bus_rdata matters only in a ready cycle, and that start is a pulse that may come at any time, busy or not. The bench responder raises ready only after it has seen a strobe, after a random delay of zero to three cycles. It drives random data on bus_rdata in every cycle that is not a ready cycle, and random low bits on mailbox reads, so only bit 31 can steer the sequence. Starts that land during a sequence are injected on purpose, with the opposite enable flag, to exercise the ignore rule.

// File: rtl/pwrreq_pkg.sv
package pwrreq_pkg;

    localparam int unsigned BUS_W = 32;

    localparam logic [BUS_W-1:0] MBOX_CMD_ADDR  = 32'h0016_1300;
    localparam logic [BUS_W-1:0] MBOX_DATA_ADDR = 32'h0016_1304;
    localparam int unsigned      MBOX_BUSY_BIT  = 31;
    localparam logic [7:0]       MBOX_OPCODE    = 8'h01;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_POLL,
        S_WR_DATA,
        S_WR_CMD,
        S_POST_POLL,
        S_RD_PWR,
        S_WR_PWR
    } seq_state_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] wdata;
    } bus_req_t;

    function automatic logic mbox_busy(input logic [BUS_W-1:0] word);
        return word[MBOX_BUSY_BIT];
    endfunction

    function automatic logic [BUS_W-1:0] mbox_cmd_word();
        logic [BUS_W-1:0] w;
        w = '0;
        w[MBOX_BUSY_BIT] = 1'b1;
        w[7:0] = MBOX_OPCODE;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] pwr_merge(input logic [BUS_W-1:0] word,
                                                   input int unsigned idx,
                                                   input logic en);
        logic [BUS_W-1:0] m;
        m = {{(BUS_W-1){1'b0}}, 1'b1} << idx;
        return en ? (word | m) : (word & ~m);
    endfunction

endpackage

// File: rtl/pwrreq_tick.sv
module pwrreq_tick #(
    parameter int unsigned TICK_CYCLES = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    generate
        if (TICK_CYCLES <= 1) begin : g_every
            assign tick = ~clr;
        end else begin : g_div
            localparam int unsigned CW = $clog2(TICK_CYCLES);
            localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST) && !clr;
        end
    endgenerate
endmodule

// File: rtl/pwrreq_timeout.sv
module pwrreq_timeout #(
    parameter int unsigned TICK_CYCLES   = 125000,
    parameter int unsigned TIMEOUT_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic expired
);
    localparam int unsigned TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_TICKS);

    logic          tick;
    logic [TW-1:0] ticks_q;

    pwrreq_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ticks_q <= '0;
        end else if (tick && ticks_q != LIMIT) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end

    assign expired = (ticks_q == LIMIT);
endmodule

// File: rtl/pwrreq_busmux.sv
module pwrreq_busmux
    import pwrreq_pkg::*;
#(
    parameter logic [31:0] PWR_ADDR = 32'h0004_5010,
    parameter int unsigned PWR_BIT  = 5
) (
    input  seq_state_e       state,
    input  logic             en,
    input  logic [BUS_W-1:0] pwr_word,
    output bus_req_t         req
);
    always_comb begin
        req = '0;
        unique case (state)
            S_PRE_POLL, S_POST_POLL: begin
                req.rd   = 1'b1;
                req.addr = MBOX_CMD_ADDR;
            end
            S_WR_DATA: begin
                req.wr    = 1'b1;
                req.addr  = MBOX_DATA_ADDR;
                req.wdata = {{(BUS_W-1){1'b0}}, en};
            end
            S_WR_CMD: begin
                req.wr    = 1'b1;
                req.addr  = MBOX_CMD_ADDR;
                req.wdata = mbox_cmd_word();
            end
            S_RD_PWR: begin
                req.rd   = 1'b1;
                req.addr = PWR_ADDR;
            end
            S_WR_PWR: begin
                req.wr    = 1'b1;
                req.addr  = PWR_ADDR;
                req.wdata = pwr_merge(pwr_word, PWR_BIT, en);
            end
            default: req = '0;
        endcase
    end
endmodule

// File: rtl/pwrreq_seq.sv
module pwrreq_seq
    import pwrreq_pkg::*;
#(
    parameter int unsigned TICK_CYCLES   = 125000,
    parameter int unsigned TIMEOUT_TICKS = 10,
    parameter logic [31:0] PWR_ADDR      = 32'h0004_5010,
    parameter int unsigned PWR_BIT       = 5,
    parameter int unsigned REV_W         = 8,
    parameter int unsigned MIN_REV       = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             enable_req,
    input  logic [REV_W-1:0] hw_rev,
    output logic [31:0]      bus_addr,
    output logic [31:0]      bus_wdata,
    output logic             bus_wr,
    output logic             bus_rd,
    input  logic [31:0]      bus_rdata,
    input  logic             bus_ready,
    output logic             done,
    output logic             error,
    output logic [1:0]       timed_out
);
    seq_state_e       state_q, state_d;
    logic             en_q;
    logic [BUS_W-1:0] pwr_q;
    logic             err_q, done_q;
    logic [1:0]       to_q;

    logic timer_clr, expired;
    logic abort, finish, capture, accept;
    logic old_rev;
    bus_req_t req;

    assign old_rev = (32'(hw_rev) < MIN_REV);

    pwrreq_timeout #(
        .TICK_CYCLES   (TICK_CYCLES),
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_timeout (
        .clk     (clk),
        .rst     (rst),
        .clr     (timer_clr),
        .expired (expired)
    );

    always_comb begin
        state_d   = state_q;
        timer_clr = 1'b0;
        abort     = 1'b0;
        finish    = 1'b0;
        capture   = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    accept    = 1'b1;
                    timer_clr = 1'b1;
                    state_d   = old_rev ? S_RD_PWR : S_PRE_POLL;
                end
            end
            S_PRE_POLL: begin
                if (bus_ready && !mbox_busy(bus_rdata)) begin
                    state_d = S_WR_DATA;
                end else if (expired) begin
                    abort   = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_WR_DATA: begin
                if (bus_ready) state_d = S_WR_CMD;
            end
            S_WR_CMD: begin
                if (bus_ready) begin
                    timer_clr = 1'b1;
                    state_d   = S_POST_POLL;
                end
            end
            S_POST_POLL: begin
                if (bus_ready && !mbox_busy(bus_rdata)) begin
                    state_d = S_RD_PWR;
                end else if (expired) begin
                    abort   = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_RD_PWR: begin
                if (bus_ready) begin
                    capture = 1'b1;
                    state_d = S_WR_PWR;
                end
            end
            S_WR_PWR: begin
                if (bus_ready) begin
                    finish  = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            en_q    <= 1'b0;
            pwr_q   <= '0;
            err_q   <= 1'b0;
            to_q    <= 2'b00;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= abort || finish;
            if (accept) begin
                en_q  <= enable_req;
                err_q <= 1'b0;
                to_q  <= 2'b00;
            end
            if (capture) begin
                pwr_q <= bus_rdata;
            end
            if (abort) begin
                err_q <= 1'b1;
                to_q  <= (state_q == S_PRE_POLL) ? 2'b01 : 2'b10;
            end
        end
    end

    pwrreq_busmux #(
        .PWR_ADDR (PWR_ADDR),
        .PWR_BIT  (PWR_BIT)
    ) u_busmux (
        .state    (state_q),
        .en       (en_q),
        .pwr_word (pwr_q),
        .req      (req)
    );

    assign bus_rd    = req.rd;
    assign bus_wr    = req.wr;
    assign bus_addr  = req.addr;
    assign bus_wdata = req.wdata;
    assign done      = done_q;
    assign error     = err_q;
    assign timed_out = to_q;
endmodule

// File: rtl/pwrreq_seq_chk.sv
module pwrreq_seq_chk #(
    parameter logic [31:0] PWR_ADDR = 32'h0004_5010
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        bus_ready,
    input logic        done,
    input logic        error,
    input logic [1:0]  timed_out
);
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    assert_hold_access_R10: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !bus_ready) |=>
            (((bus_rd || bus_wr) && $stable(bus_addr) && $stable(bus_wdata)) || timed_out != 2'b00));

    assert_cmd_word_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 32'h0016_1300) |-> (bus_wdata == 32'h8000_0001));

    assert_data_word_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 32'h0016_1304) |-> (bus_wdata[31:1] == 31'd0));

    assert_no_pwr_write_after_abort_R5: assert property (@(posedge clk) disable iff (rst)
        (timed_out != 2'b00) |-> !(bus_wr && bus_addr == PWR_ADDR));

    assert_timeout_flags_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(timed_out) && ((timed_out != 2'b00) -> error));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_error_held_R9: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> error);
endmodule

bind pwrreq_seq pwrreq_seq_chk #(.PWR_ADDR(PWR_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_ready (bus_ready),
    .done      (done),
    .error     (error),
    .timed_out (timed_out)
);

// File: tb/sim_pwrreq_seq.sv
`timescale 1ns/1ps
module sim_pwrreq_seq;
    localparam int unsigned TICKS_T = 4;
    localparam int unsigned LIM     = 10;
    localparam logic [31:0] PADDR   = 32'h0004_5010;
    localparam int unsigned PBIT    = 5;
    localparam logic [31:0] CMD_A   = 32'h0016_1300;
    localparam logic [31:0] DATA_A  = 32'h0016_1304;
    localparam int          WIN     = TICKS_T * LIM;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        enable_req = 1'b0;
    logic [7:0]  hw_rev = 8'd30;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_wr, bus_rd, bus_ready;
    logic        done, error;
    logic [1:0]  timed_out;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    pwrreq_seq #(
        .TICK_CYCLES   (TICKS_T),
        .TIMEOUT_TICKS (LIM),
        .PWR_ADDR      (PADDR),
        .PWR_BIT       (PBIT),
        .REV_W         (8),
        .MIN_REV       (30)
    ) u0 (
        .clk (clk), .rst (rst), .start (start), .enable_req (enable_req),
        .hw_rev (hw_rev), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
        .bus_ready (bus_ready), .done (done), .error (error),
        .timed_out (timed_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // responder configuration, written by the stimulus
    logic        cfg_load = 1'b0;
    int          cfg_pre = 0, cfg_post = 0, cfg_lat = 0;
    logic [31:0] cfg_pwr = 32'h0;

    // responder state
    logic [31:0] pwr_mem;
    int          busy_left;
    int          lat_cnt;
    int          post_busy;
    int          lg_n;
    logic [31:0] lg_addr [0:63];
    logic [31:0] lg_data [0:63];
    logic        lg_wr   [0:63];
    int          lg_cyc  [0:63];
    int          both_strobes = 0;

    initial begin
        bus_ready = 1'b0;
        bus_rdata = 32'h0;
        pwr_mem   = 32'h0;
        busy_left = 0;
        lat_cnt   = 0;
        post_busy = 0;
        lg_n      = 0;
    end

    always @(posedge clk) begin
        bus_ready <= 1'b0;
        bus_rdata <= $urandom;
        if (bus_rd && bus_wr) both_strobes <= both_strobes + 1;
        if (cfg_load) begin
            pwr_mem   <= cfg_pwr;
            busy_left <= cfg_pre;
            post_busy <= cfg_post;
            lg_n      <= 0;
            lat_cnt   <= 0;
        end else if ((bus_rd || bus_wr) && !bus_ready) begin
            if (lat_cnt > 0) begin
                lat_cnt <= lat_cnt - 1;
            end else begin
                bus_ready <= 1'b1;
                lat_cnt   <= (cfg_lat > 0) ? int'($urandom_range(0, cfg_lat)) : 0;
                if (lg_n < 64) begin
                    lg_addr[lg_n] <= bus_addr;
                    lg_data[lg_n] <= bus_wdata;
                    lg_wr[lg_n]   <= bus_wr;
                    lg_cyc[lg_n]  <= cyc;
                    lg_n          <= lg_n + 1;
                end
                if (bus_rd) begin
                    if (bus_addr == CMD_A) begin
                        if (busy_left != 0) begin
                            bus_rdata <= 32'h8000_0000 | ($urandom & 32'h0000_ffff);
                            if (busy_left > 0) busy_left <= busy_left - 1;
                        end else begin
                            bus_rdata <= $urandom & 32'h7fff_ffff;
                        end
                    end else if (bus_addr == PADDR) begin
                        bus_rdata <= pwr_mem;
                    end
                end else begin
                    if (bus_addr == CMD_A) busy_left <= post_busy;
                    else if (bus_addr == PADDR) pwr_mem <= bus_wdata;
                end
            end
        end
    end

    function automatic logic [31:0] exp_pwr(input logic [31:0] v, input logic en);
        return en ? (v | (32'd1 << PBIT)) : (v & ~(32'd1 << PBIT));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_acc(input int i, input logic [31:0] a, input logic w);
        return (i < lg_n) && lg_addr[i] == a && lg_wr[i] == w;
    endfunction

    int start_cyc;
    int done_cyc;

    task automatic configure(input int pre, input int post, input logic [31:0] pw,
                             input int lat);
        @(negedge clk);
        cfg_pre = pre; cfg_post = post; cfg_pwr = pw; cfg_lat = lat;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // pulse start, optionally inject a second start during the sequence
    task automatic launch(input logic en, input logic [7:0] rev, input bit inject);
        int n;
        enable_req = en; hw_rev = rev; start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            if (inject && n == 3) begin
                start = 1'b1; enable_req = ~en; hw_rev = 8'd0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        done_cyc = cyc;
        chk(done == 1'b1, "R9 done reached", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic run_good(input logic en, input int pre, input int post,
                            input logic [31:0] pw, input int lat, input bit inject);
        bit ok;
        int b;
        configure(pre, post, pw, lat);
        launch(en, 8'd30 + 8'($urandom_range(0, 40)), inject);
        ok = 1'b1;
        for (int i = 0; i <= pre; i++) if (!is_acc(i, CMD_A, 1'b0)) ok = 1'b0;
        chk(ok, "R1 pre-wait reads", 32'(lg_n), 32'(pre + post + 6));
        b = pre + 1;
        chk(is_acc(b, DATA_A, 1'b1) && lg_data[b] == {31'd0, en},
            "R2 data word", lg_data[b], {31'd0, en});
        chk(is_acc(b + 1, CMD_A, 1'b1) && lg_data[b + 1] == 32'h8000_0001,
            "R3 command word", lg_data[b + 1], 32'h8000_0001);
        ok = 1'b1;
        for (int i = b + 2; i <= b + 2 + post; i++) if (!is_acc(i, CMD_A, 1'b0)) ok = 1'b0;
        if (!is_acc(b + 3 + post, PADDR, 1'b0)) ok = 1'b0;
        chk(ok, "R4 post-wait before power access", 32'(lg_n), 32'(pre + post + 6));
        chk(is_acc(b + 4 + post, PADDR, 1'b1) && lg_n == pre + post + 6 &&
            pwr_mem == exp_pwr(pw, en),
            inject ? "R8 late start ignored" : "R6 power read-modify-write",
            pwr_mem, exp_pwr(pw, en));
        chk(error == 1'b0 && timed_out == 2'b00, "R9 no error flags",
            {29'd0, error, timed_out}, 32'd0);
    endtask

    task automatic run_old(input logic en, input logic [31:0] pw, input int lat);
        configure(0, 0, pw, lat);
        launch(en, 8'($urandom_range(0, 29)), 1'b0);
        chk(lg_n == 2 && is_acc(0, PADDR, 1'b0) && is_acc(1, PADDR, 1'b1) &&
            pwr_mem == exp_pwr(pw, en), "R7 skip path", pwr_mem, exp_pwr(pw, en));
    endtask

    task automatic run_timeout(input bit second, input logic en, input logic [31:0] pw);
        bit ok;
        int d;
        int first_post;
        configure(second ? 1 : -1, second ? -1 : 0, pw, 1);
        launch(en, 8'd31, 1'b0);
        ok = (lg_n > 0);
        for (int i = 0; i < lg_n && i < 64; i++) if (lg_addr[i] == PADDR) ok = 1'b0;
        chk(ok && pwr_mem == pw, "R5 power untouched on abort", pwr_mem, pw);
        chk(error == 1'b1 && timed_out == (second ? 2'b10 : 2'b01), "R5 abort flags",
            {29'd0, error, timed_out}, second ? 32'd6 : 32'd5);
        first_post = 0;
        if (second) begin
            for (int i = 0; i < lg_n && i < 64; i++)
                if (lg_wr[i] && lg_addr[i] == CMD_A) first_post = lg_cyc[i];
            d = done_cyc - first_post;
        end else begin
            d = done_cyc - start_cyc;
        end
        chk(d >= WIN && d <= WIN + 6, "R5 timeout window", 32'(d), 32'(WIN));
        repeat (5) @(negedge clk);
        chk(error == 1'b1 && timed_out != 2'b00, "R9 error held while idle",
            {29'd0, error, timed_out}, 32'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_rd == 1'b0 && bus_wr == 1'b0 && done == 1'b0 && error == 1'b0 &&
            timed_out == 2'b00, "R11 reset state",
            {27'd0, bus_rd, bus_wr, done, error, timed_out[0]}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        run_good(1'b1, 0, 0, 32'h0000_0000, 0, 1'b0);
        run_good(1'b0, 3, 2, 32'hffff_ffff, 2, 1'b0);
        run_good(1'b1, 2, 4, 32'ha5a5_0000, 3, 1'b1);
        run_old(1'b1, 32'h1234_0000, 1);
        run_old(1'b0, 32'h0000_0020, 0);
        run_timeout(1'b0, 1'b1, 32'h0f0f_0f0f);
        // the next start clears the flags at acceptance
        configure(0, 0, 32'h0, 0);
        enable_req = 1'b1; hw_rev = 8'd40; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(error == 1'b0 && timed_out == 2'b00, "R9 flags cleared by start",
            {29'd0, error, timed_out}, 32'd0);
        while (!done) @(negedge clk);
        @(negedge clk);
        run_timeout(1'b1, 1'b0, 32'hffff_ffdf);

        for (int k = 0; k < 24; k++) begin
            logic        en;
            logic [31:0] pw;
            en = 1'($urandom_range(0, 1));
            pw = $urandom;
            if (k % 6 == 5) run_old(en, pw, int'($urandom_range(0, 3)));
            else run_good(en, int'($urandom_range(0, 4)), int'($urandom_range(0, 4)),
                          pw, int'($urandom_range(0, 3)), (k % 4 == 1));
        end

        chk(both_strobes == 0, "R10 single strobe", 32'(both_strobes), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd20241);
        #(8 * 150000);
        tests++;
        fails++;
        $display("[TB] FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule